// File: doc/BRIEF.md
# Byte Programming Sequencer with Pulse-and-Verify

This block drives an electrically programmable 64K x 8 memory through a multiplexed address/data interface. It writes a range of bytes taken from a host-side read port. A single start command supplies the first and last address and a mode bit. The sequencer then brings up the high core supply, latches each address, drives the data, and applies timed program pulses. During a pulse it also requests the high voltage on the shared output-enable pin. Between pulses it reads the cell back to check the result.

Two orderings are available. In per-byte mode each address is pulsed and verified until it matches or the retry limit is reached. In batch mode every address first receives one pulse with no verify. A second pass then starts again at the first address and verifies each byte, pulsing again only where the read-back differs. In both modes the core supply is then dropped to its normal level, and every byte is read again and compared with freshly fetched source data. The outcome is reported as pass or fail, together with the address that failed.

Before a byte receives its first pulse, its current contents are read. A byte that would need any bit raised from 0 to 1 is rejected on the spot, because a program pulse can only clear bits.

Top module: `byte_prog_seq`

## Requirements
- R1: After reset, `busy`, `pass`, `fail`, `ale`, `bus_oe`, `core_hi_req` and `pin_hv_req` are 0, and `oe_n` is 1.
- R2: A start in idle raises `core_hi_req` in the same clock edge that raises `busy`. At least SUPPLY_CYC cycles pass before the first `ale` pulse. `pin_hv_req` is never high while `core_hi_req` is low.
- R3: Each address visit puts the upper address byte on `addr_hi` and the lower byte on `bus_out`. It raises `ale` for exactly LATCH_CYC cycles and keeps the address driven for LATCH_CYC cycles after `ale` falls.
- R4: A program pulse holds `ale` high for exactly PULSE_CYC cycles with `pin_hv_req` high and the data byte stable on `bus_out`. The data and `pin_hv_req` are present for exactly SETUP_CYC cycles before `ale` rises and for exactly HOLD_CYC cycles after it falls.
- R5: Every read holds `oe_n` low for exactly READ_CYC cycles, with `bus_oe` and `pin_hv_req` low throughout. The byte on `bus_in` is taken in the last of those cycles.
- R6: In per-byte mode (`batch_mode`=0), each pulse is followed by a verify read. A mismatch re-pulses the byte. The MAX_TRY-th failing verify of one address ends the run with `fail`=1 and `fail_addr` set to that address. The failing-verify count restarts at zero for every address.
- R7: In batch mode (`batch_mode`=1), every address from first to last gets exactly one pulse with no verify read. A second pass from the first address then verifies each byte and re-pulses only on mismatch, with the same MAX_TRY limit.
- R8: Before the first pulse of an address, the current byte is read. If any bit is 0 in the cell and 1 in the source data, the run fails at that address and that address receives no pulse.
- R9: After the last address is programmed, `core_hi_req` drops and SUPPLY_CYC cycles elapse. Every address from first to last is then read with `core_hi_req` low and compared with the source byte. The first mismatch fails the run at that address.
- R10: Each address visit issues exactly one single-cycle `src_rd_en` with `src_addr` equal to the address. `src_data` is taken one cycle later and held for the whole visit.
- R11: A run that finishes every compare sets `pass`=1. `pass`, `fail` and `fail_addr` hold until the next start, which clears `pass` and `fail`. `pass` and `fail` are never both 1, and both are 0 while `busy`=1.
- R12: `start` is ignored while `busy`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (sampled only when idle) |
| batch_mode | input | 1 | 0: verify per byte, 1: pulse all then verify |
| first_addr | input | ADDR_W | First address of the range |
| last_addr | input | ADDR_W | Last address of the range (inclusive) |
| src_rd_en | output | 1 | Host source read request |
| src_addr | output | ADDR_W | Host source read address |
| src_data | input | 8 | Host source byte, one cycle after the request |
| ale | output | 1 | Address latch / program pulse strobe |
| bus_out | output | 8 | Value driven on the shared address/data bus |
| bus_oe | output | 1 | Drive enable for the shared bus |
| bus_in | input | 8 | Value read from the shared bus |
| addr_hi | output | ADDR_W-8 | Upper address byte |
| oe_n | output | 1 | Output enable to the memory, active low |
| core_hi_req | output | 1 | Request for the raised core supply |
| pin_hv_req | output | 1 | Request for high voltage on the output-enable pin |
| busy | output | 1 | Run in progress |
| pass | output | 1 | Last run completed with all bytes matching |
| fail | output | 1 | Last run stopped on an error |
| fail_addr | output | ADDR_W | Address at which the last run failed |

## Verification
The bench models the memory with a per-address count of pulses needed before the bits clear, which lets it aim at the retry boundary. An address that needs exactly MAX_TRY pulses must pass, and a following address with the same need must pass too. A design that fails one verify early, or that forgets to clear the count between addresses, fails one of these runs. A design that allows one extra pulse is caught by the pulse count of an address that needs MAX_TRY+1 pulses. In batch mode, the recorded order of pulsed addresses shows whether verify was wrongly folded into the first pass. A cell holding a 0 where the source wants a 1 must fail with no pulse at all. A byte that reads wrong only at normal supply shows whether the final compare is really done after the supply drops. Pulse, setup, hold, latch and read windows are measured cycle by cycle, so an off-by-one timer shows up directly.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

    localparam int unsigned BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RAMP,
        S_FETCH,
        S_FETCH_W,
        S_LATCH_HI,
        S_LATCH_LO,
        S_READ,
        S_CHECK,
        S_DSET,
        S_PULSE,
        S_DHOLD,
        S_NEXT,
        S_PWRDN
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_PROG,
        PH_REVISIT,
        PH_FINAL
    } phase_e;

    typedef enum logic [1:0] {
        RD_PRE,
        RD_VERIFY,
        RD_FINAL
    } rd_kind_e;

    typedef struct packed {
        logic ale;
        logic drive;
        logic oe_n;
        logic hv;
        logic sel_data;
    } pin_ctl_t;

    function automatic int unsigned cyc_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // A pulse can only clear bits: any bit wanted at 1 over a stored 0 is unreachable.
    function automatic logic needs_raise(input byte_t have, input byte_t want);
        return |(want & ~have);
    endfunction

    function automatic pin_ctl_t pins_of(input seq_state_e st);
        pin_ctl_t p;
        p = '{ale: 1'b0, drive: 1'b0, oe_n: 1'b1, hv: 1'b0, sel_data: 1'b0};
        case (st)
            S_LATCH_HI: begin p.ale = 1'b1; p.drive = 1'b1; end
            S_LATCH_LO: p.drive = 1'b1;
            S_READ:     p.oe_n = 1'b0;
            S_DSET:     begin p.drive = 1'b1; p.hv = 1'b1; p.sel_data = 1'b1; end
            S_PULSE:    begin p.ale = 1'b1; p.drive = 1'b1; p.hv = 1'b1; p.sel_data = 1'b1; end
            S_DHOLD:    begin p.drive = 1'b1; p.hv = 1'b1; p.sel_data = 1'b1; end
            default:    ;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/prog_seq_timer.sv
module prog_seq_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/prog_seq_addr.sv
module prog_seq_addr #(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic [ADDR_W-1:0] first_in,
    input  logic [ADDR_W-1:0] last_in,
    input  logic              rewind,
    input  logic              step,
    output logic [ADDR_W-1:0] cur,
    output logic              at_last
);
    logic [ADDR_W-1:0] first_q;
    logic [ADDR_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q <= '0;
            last_q  <= '0;
            cur     <= '0;
        end else if (cap) begin
            first_q <= first_in;
            last_q  <= last_in;
            cur     <= first_in;
        end else if (rewind) begin
            cur <= first_q;
        end else if (step) begin
            cur <= cur + 1'b1;
        end
    end

    assign at_last = (cur == last_q);

    // R10: the walk only moves forward by one address at a time
    p_step_by_one_r10: assert property (@(posedge clk) disable iff (rst)
        (step && !cap && !rewind) |=> (cur == $past(cur) + 1'b1));
endmodule

// File: rtl/prog_seq_retry.sv
module prog_seq_retry #(
    parameter int unsigned MAX_TRY = 25
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);
    localparam int unsigned RW = $clog2(MAX_TRY + 1);
    logic [RW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign at_limit = (cnt == RW'(MAX_TRY - 1));

    // R6: failing verifies of one address never reach the limit without ending the run
    p_retry_bound_r6: assert property (@(posedge clk) disable iff (rst)
        cnt < RW'(MAX_TRY));
endmodule

// File: rtl/byte_prog_seq.sv
module byte_prog_seq
    import prog_seq_pkg::*;
#(
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned PULSE_CYC  = 12500,
    parameter int unsigned SETUP_CYC  = 500,
    parameter int unsigned HOLD_CYC   = 500,
    parameter int unsigned LATCH_CYC  = 25,
    parameter int unsigned READ_CYC   = 38,
    parameter int unsigned SUPPLY_CYC = 500,
    parameter int unsigned MAX_TRY    = 25
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic                     batch_mode,
    input  logic [ADDR_W-1:0]        first_addr,
    input  logic [ADDR_W-1:0]        last_addr,
    output logic                     src_rd_en,
    output logic [ADDR_W-1:0]        src_addr,
    input  logic [7:0]               src_data,
    output logic                     ale,
    output logic [7:0]               bus_out,
    output logic                     bus_oe,
    input  logic [7:0]               bus_in,
    output logic [ADDR_W-9:0]        addr_hi,
    output logic                     oe_n,
    output logic                     core_hi_req,
    output logic                     pin_hv_req,
    output logic                     busy,
    output logic                     pass,
    output logic                     fail,
    output logic [ADDR_W-1:0]        fail_addr
);
    localparam int unsigned TMR_MAX = cyc_max(cyc_max(cyc_max(PULSE_CYC, SETUP_CYC),
                                      cyc_max(HOLD_CYC, LATCH_CYC)), cyc_max(READ_CYC, SUPPLY_CYC));
    localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);

    seq_state_e st, st_n;
    phase_e     phase;
    rd_kind_e   rd_kind;
    byte_t      data_q, rd_q;
    logic       batch_q, core_q, pass_q, fail_q;
    logic [ADDR_W-1:0] fail_addr_q;

    logic             tmr_load, tmr_zero;
    logic [TMR_W-1:0] tmr_val;
    logic             cap, rewind, step, at_last;
    logic             retry_clr, retry_inc, retry_limit;
    logic             go_fail, go_pass;
    logic [ADDR_W-1:0] cur;
    pin_ctl_t         pins;

    prog_seq_timer #(.W(TMR_W)) i_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    prog_seq_addr #(.ADDR_W(ADDR_W)) i_addr (
        .clk(clk), .rst(rst), .cap(cap), .first_in(first_addr), .last_in(last_addr),
        .rewind(rewind), .step(step), .cur(cur), .at_last(at_last)
    );

    prog_seq_retry #(.MAX_TRY(MAX_TRY)) i_retry (
        .clk(clk), .rst(rst), .clr(retry_clr), .inc(retry_inc), .at_limit(retry_limit)
    );

    always_comb begin
        st_n      = st;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        cap       = 1'b0;
        rewind    = 1'b0;
        step      = 1'b0;
        retry_inc = 1'b0;
        go_fail   = 1'b0;
        go_pass   = 1'b0;
        case (st)
            S_IDLE: if (start) begin
                st_n = S_RAMP; cap = 1'b1;
                tmr_load = 1'b1; tmr_val = TMR_W'(SUPPLY_CYC - 1);
            end
            S_RAMP, S_PWRDN: if (tmr_zero) st_n = S_FETCH;
            S_FETCH:   st_n = S_FETCH_W;
            S_FETCH_W: begin
                st_n = S_LATCH_HI;
                tmr_load = 1'b1; tmr_val = TMR_W'(LATCH_CYC - 1);
            end
            S_LATCH_HI: if (tmr_zero) begin
                st_n = S_LATCH_LO;
                tmr_load = 1'b1; tmr_val = TMR_W'(LATCH_CYC - 1);
            end
            S_LATCH_LO: if (tmr_zero) begin
                st_n = S_READ;
                tmr_load = 1'b1; tmr_val = TMR_W'(READ_CYC - 1);
            end
            S_READ: if (tmr_zero) st_n = S_CHECK;
            S_CHECK: begin
                case (rd_kind)
                    RD_PRE: begin
                        if (needs_raise(rd_q, data_q)) go_fail = 1'b1;
                        else begin
                            st_n = S_DSET;
                            tmr_load = 1'b1; tmr_val = TMR_W'(SETUP_CYC - 1);
                        end
                    end
                    RD_VERIFY: begin
                        if (rd_q == data_q) st_n = S_NEXT;
                        else if (retry_limit) go_fail = 1'b1;
                        else begin
                            retry_inc = 1'b1;
                            st_n = S_DSET;
                            tmr_load = 1'b1; tmr_val = TMR_W'(SETUP_CYC - 1);
                        end
                    end
                    default: begin
                        if (rd_q == data_q) st_n = S_NEXT;
                        else go_fail = 1'b1;
                    end
                endcase
            end
            S_DSET: if (tmr_zero) begin
                st_n = S_PULSE;
                tmr_load = 1'b1; tmr_val = TMR_W'(PULSE_CYC - 1);
            end
            S_PULSE: if (tmr_zero) begin
                st_n = S_DHOLD;
                tmr_load = 1'b1; tmr_val = TMR_W'(HOLD_CYC - 1);
            end
            S_DHOLD: if (tmr_zero) begin
                if (phase == PH_PROG && batch_q) st_n = S_NEXT;
                else begin
                    st_n = S_READ;
                    tmr_load = 1'b1; tmr_val = TMR_W'(READ_CYC - 1);
                end
            end
            S_NEXT: begin
                if (!at_last) begin
                    step = 1'b1; st_n = S_FETCH;
                end else if (phase == PH_FINAL) begin
                    go_pass = 1'b1; st_n = S_IDLE;
                end else if (phase == PH_PROG && batch_q) begin
                    rewind = 1'b1; st_n = S_FETCH;
                end else begin
                    rewind = 1'b1; st_n = S_PWRDN;
                    tmr_load = 1'b1; tmr_val = TMR_W'(SUPPLY_CYC - 1);
                end
            end
            default: st_n = S_IDLE;
        endcase
        if (go_fail) st_n = S_IDLE;
    end

    assign retry_clr = cap || (st == S_NEXT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= S_IDLE;
            phase       <= PH_PROG;
            rd_kind     <= RD_PRE;
            data_q      <= '0;
            rd_q        <= '0;
            batch_q     <= 1'b0;
            core_q      <= 1'b0;
            pass_q      <= 1'b0;
            fail_q      <= 1'b0;
            fail_addr_q <= '0;
        end else begin
            st <= st_n;
            if (cap) begin
                batch_q     <= batch_mode;
                phase       <= PH_PROG;
                core_q      <= 1'b1;
                pass_q      <= 1'b0;
                fail_q      <= 1'b0;
                fail_addr_q <= '0;
            end
            if (st == S_FETCH_W) begin
                data_q  <= src_data;
                rd_kind <= (phase == PH_PROG)    ? RD_PRE :
                           (phase == PH_REVISIT) ? RD_VERIFY : RD_FINAL;
            end
            if (st == S_READ && tmr_zero) rd_q <= bus_in;
            if (st == S_DHOLD && tmr_zero) rd_kind <= RD_VERIFY;
            if (st == S_NEXT && at_last && phase != PH_FINAL) begin
                if (phase == PH_PROG && batch_q) phase <= PH_REVISIT;
                else begin
                    phase  <= PH_FINAL;
                    core_q <= 1'b0;
                end
            end
            if (go_fail) begin
                fail_q      <= 1'b1;
                fail_addr_q <= cur;
                core_q      <= 1'b0;
            end
            if (go_pass) pass_q <= 1'b1;
        end
    end

    assign pins        = pins_of(st);
    assign ale         = pins.ale;
    assign bus_oe      = pins.drive;
    assign oe_n        = pins.oe_n;
    assign pin_hv_req  = pins.hv;
    assign bus_out     = pins.sel_data ? data_q : cur[7:0];
    assign addr_hi     = cur[ADDR_W-1:BYTE_W];
    assign src_rd_en   = (st == S_FETCH);
    assign src_addr    = cur;
    assign core_hi_req = core_q;
    assign busy        = (st != S_IDLE);
    assign pass        = pass_q;
    assign fail        = fail_q;
    assign fail_addr   = fail_addr_q;

    // Length of the current ALE high run, used to check the pulse width
    logic [TMR_W:0] ale_run;
    always_ff @(posedge clk) begin
        if (rst || !ale) ale_run <= '0;
        else             ale_run <= ale_run + 1'b1;
    end

    p_pulse_len_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(ale) && pin_hv_req) |-> (ale_run == (TMR_W+1)'(PULSE_CYC)));
    p_pulse_data_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (ale && pin_hv_req && $past(ale)) |-> $stable(bus_out));
    p_read_bus_free_r5: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> (!bus_oe && !pin_hv_req));
    p_hv_needs_core_r2: assert property (@(posedge clk) disable iff (rst)
        pin_hv_req |-> core_hi_req);
    p_fetch_single_r10: assert property (@(posedge clk) disable iff (rst)
        src_rd_en |=> !src_rd_en);
    p_status_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(pass && fail));
    p_busy_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!pass && !fail));
    p_start_ignored_r12: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(core_hi_req) || !busy || $past(st) == S_NEXT || $past(go_fail));
endmodule

// File: tb/test_byte_prog_seq.sv
module test_byte_prog_seq;
    localparam int PULSE_CYC  = 20;
    localparam int SETUP_CYC  = 4;
    localparam int HOLD_CYC   = 3;
    localparam int LATCH_CYC  = 2;
    localparam int READ_CYC   = 3;
    localparam int SUPPLY_CYC = 6;
    localparam int MAX_TRY    = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0, batch_mode = 1'b0;
    logic [15:0] first_addr = '0, last_addr = '0;
    logic src_rd_en, ale, bus_oe, oe_n, core_hi_req, pin_hv_req, busy, pass, fail;
    logic [15:0] src_addr, fail_addr;
    logic [7:0] src_data = '0, bus_out, bus_in;
    logic [7:0] addr_hi;

    always #2 clk = ~clk;

    byte_prog_seq #(
        .ADDR_W(16), .PULSE_CYC(PULSE_CYC), .SETUP_CYC(SETUP_CYC), .HOLD_CYC(HOLD_CYC),
        .LATCH_CYC(LATCH_CYC), .READ_CYC(READ_CYC), .SUPPLY_CYC(SUPPLY_CYC), .MAX_TRY(MAX_TRY)
    ) i_byte_prog_seq (
        .clk(clk), .rst(rst), .start(start), .batch_mode(batch_mode),
        .first_addr(first_addr), .last_addr(last_addr),
        .src_rd_en(src_rd_en), .src_addr(src_addr), .src_data(src_data),
        .ale(ale), .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in), .addr_hi(addr_hi),
        .oe_n(oe_n), .core_hi_req(core_hi_req), .pin_hv_req(pin_hv_req),
        .busy(busy), .pass(pass), .fail(fail), .fail_addr(fail_addr)
    );

    // Host source memory and device configuration (written by the stimulus only)
    logic [7:0] src [256];
    logic [7:0] dev_init [256];
    int         need [256];
    logic       fade_en = 1'b0;
    logic [15:0] fade_addr = '0;
    logic       mon_clr = 1'b0;

    always @(posedge clk) if (src_rd_en) src_data <= src[src_addr[7:0]];

    // Device model and interface monitor
    logic [7:0] dev [256];
    int hits [256];
    logic [15:0] lat = '0;
    logic [15:0] plog [16];
    logic [7:0] pdata = '0;
    logic ale_q = 1'b0, oe_q = 1'b1, hv_q = 1'b0, in_post = 1'b0, seen_ale = 1'b0;
    int hi_len = 0, pre_len = 0, post_len = 0, rd_len = 0, core_cyc = 0;
    int n_pulse = 0, n_read = 0, n_read_low = 0, n_fetch = 0;
    int err2 = 0, err3 = 0, err4 = 0, err5 = 0;

    assign bus_in = oe_n ? 8'h00 :
        (dev[lat[7:0]] ^ ((fade_en && lat == fade_addr && !core_hi_req) ? 8'h01 : 8'h00));

    always @(negedge clk) begin
        if (mon_clr) begin
            for (int i = 0; i < 256; i++) begin
                dev[i]  <= dev_init[i];
                hits[i] <= 0;
            end
            n_pulse <= 0; n_read <= 0; n_read_low <= 0; n_fetch <= 0;
            err2 <= 0; err3 <= 0; err4 <= 0; err5 <= 0;
            seen_ale <= 1'b0; core_cyc <= 0;
        end else if (!rst) begin
            ale_q <= ale; oe_q <= oe_n; hv_q <= pin_hv_req;
            hi_len <= ale ? hi_len + 1 : 0;
            core_cyc <= core_hi_req ? core_cyc + 1 : 0;
            if (pin_hv_req && !core_hi_req) err2 <= err2 + 1;
            if (src_rd_en) n_fetch <= n_fetch + 1;
            if (!pin_hv_req) begin
                pre_len <= 0; post_len <= 0; in_post <= 1'b0;
            end else if (!ale) begin
                if (in_post) post_len <= post_len + 1;
                else         pre_len  <= pre_len + 1;
            end
            if (hv_q && !pin_hv_req && post_len != HOLD_CYC) err4 <= err4 + 1;
            if (ale && !ale_q) begin
                if (pin_hv_req) begin
                    pdata <= bus_out;
                    if (pre_len != SETUP_CYC) err4 <= err4 + 1;
                end
                if (!seen_ale) begin
                    seen_ale <= 1'b1;
                    if (core_cyc < SUPPLY_CYC) err2 <= err2 + 1;
                end
            end
            if (ale && ale_q && pin_hv_req && bus_out != pdata) err4 <= err4 + 1;
            if (!ale && ale_q) begin
                if (pin_hv_req) begin
                    in_post <= 1'b1; post_len <= 1;
                    if (hi_len != PULSE_CYC) err4 <= err4 + 1;
                    if (n_pulse < 16) plog[n_pulse] <= lat;
                    n_pulse <= n_pulse + 1;
                    hits[lat[7:0]] <= hits[lat[7:0]] + 1;
                    if (hits[lat[7:0]] + 1 >= need[lat[7:0]])
                        dev[lat[7:0]] <= dev[lat[7:0]] & bus_out;
                end else begin
                    lat <= {addr_hi, bus_out};
                    if (hi_len != LATCH_CYC || !bus_oe) err3 <= err3 + 1;
                end
            end
            if (!oe_n) begin
                rd_len <= rd_len + 1;
                if (bus_oe || pin_hv_req) err5 <= err5 + 1;
            end
            if (oe_n && !oe_q) begin
                n_read <= n_read + 1;
                if (!core_hi_req) n_read_low <= n_read_low + 1;
                if (rd_len != READ_CYC) err5 <= err5 + 1;
                rd_len <= 0;
            end
        end
    end

    int n_chk = 0, n_bad = 0, cyc = 0;

    task automatic summary_and_end();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    task automatic tick();
        @(posedge clk); #1;
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
            summary_and_end();
        end
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic dev_fill(input logic [7:0] v);
        for (int i = 0; i < 256; i++) begin
            dev_init[i] = v; need[i] = 1; src[i] = 8'(i * 37 + 5) & 8'hBF;
        end
        fade_en = 1'b0;
    endtask

    task automatic kick(input logic [15:0] f, input logic [15:0] l, input logic m);
        mon_clr = 1'b1; tick(); mon_clr = 1'b0;
        first_addr = f; last_addr = l; batch_mode = m; start = 1'b1;
        tick(); start = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        for (int i = 0; i < 20000 && busy; i++) tick();
        chk(req, "run ends", int'(busy), 0);
        tick(); tick();
    endtask

    task automatic t_reset();
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "pass/fail", int'({pass, fail}), 0);
        chk("R1", "ale/bus_oe/oe_n", int'({ale, bus_oe, oe_n}), 1);
        chk("R1", "supplies", int'({core_hi_req, pin_hv_req}), 0);
    endtask

    task automatic t_per_byte();
        dev_fill(8'hFF);
        kick(16'h0010, 16'h0013, 1'b0);
        chk("R2", "busy and core after start", int'({busy, core_hi_req}), 3);
        wait_idle("R6");
        chk("R11", "pass", int'({pass, fail}), 2);
        for (int a = 16'h10; a <= 16'h13; a++) chk("R6", "cell programmed", dev[a], src[a]);
        chk("R6", "pulse count", n_pulse, 4);
        chk("R5", "read count pre+verify+final", n_read, 12);
        chk("R9", "reads at normal supply", n_read_low, 4);
        chk("R10", "fetch count", n_fetch, 8);
        chk("R2", "supply order errors", err2, 0);
        chk("R3", "latch errors", err3, 0);
        chk("R4", "pulse timing errors", err4, 0);
        chk("R5", "read window errors", err5, 0);
        chk("R2", "supplies off at end", int'({core_hi_req, pin_hv_req}), 0);
        repeat (20) tick();
        chk("R11", "pass sticky", int'({busy, pass}), 1);
    endtask

    task automatic t_retry_edge();
        dev_fill(8'hFF);
        need[16'h30] = MAX_TRY; need[16'h31] = MAX_TRY;
        kick(16'h0030, 16'h0031, 1'b0);
        wait_idle("R6");
        chk("R6", "retry limit met exactly passes", int'({pass, fail}), 2);
        chk("R6", "pulses with count reset per address", n_pulse, 2 * MAX_TRY);
        chk("R4", "pulse timing errors", err4, 0);
    endtask

    task automatic t_retry_fail();
        dev_fill(8'hFF);
        need[16'h38] = MAX_TRY + 1;
        kick(16'h0037, 16'h0039, 1'b0);
        wait_idle("R6");
        chk("R6", "fail flag", int'({pass, fail}), 1);
        chk("R6", "fail_addr", fail_addr, 16'h0038);
        chk("R6", "pulses before giving up", n_pulse, 1 + MAX_TRY);
        chk("R2", "core dropped after fail", int'(core_hi_req), 0);
    endtask

    task automatic t_batch();
        dev_fill(8'hFF);
        need[16'h21] = 3;
        kick(16'h0020, 16'h0022, 1'b1);
        chk("R11", "fail cleared by new start", int'({busy, fail}), 2);
        wait_idle("R7");
        chk("R7", "pass", int'({pass, fail}), 2);
        chk("R7", "pulse count", n_pulse, 5);
        chk("R7", "pulse order 0", plog[0], 16'h0020);
        chk("R7", "pulse order 1", plog[1], 16'h0021);
        chk("R7", "pulse order 2", plog[2], 16'h0022);
        chk("R7", "pulse order 3", plog[3], 16'h0021);
        chk("R7", "pulse order 4", plog[4], 16'h0021);
        chk("R7", "read count", n_read, 11);
        chk("R10", "fetch count", n_fetch, 9);
        chk("R4", "pulse timing errors", err4, 0);
        for (int a = 16'h20; a <= 16'h22; a++) chk("R7", "cell programmed", dev[a], src[a]);
    endtask

    task automatic t_raise();
        dev_fill(8'hFF);
        dev_init[16'h40] = 8'h0F; src[16'h40] = 8'hF0;
        kick(16'h003F, 16'h0041, 1'b0);
        wait_idle("R8");
        chk("R8", "fail flag", int'({pass, fail}), 1);
        chk("R8", "fail_addr", fail_addr, 16'h0040);
        chk("R8", "only preceding address pulsed", n_pulse, 1);
        chk("R8", "cell untouched", dev[16'h40], 8'h0F);
    endtask

    task automatic t_final_fade();
        dev_fill(8'hFF);
        fade_en = 1'b1; fade_addr = 16'h0051;
        kick(16'h0050, 16'h0052, 1'b0);
        wait_idle("R9");
        chk("R9", "fail flag", int'({pass, fail}), 1);
        chk("R9", "fail_addr", fail_addr, 16'h0051);
        chk("R9", "reads at normal supply", n_read_low, 2);
        chk("R9", "all programmed first", n_pulse, 3);
    endtask

    task automatic t_busy_start();
        dev_fill(8'hFF);
        kick(16'h0060, 16'h0060, 1'b0);
        repeat (10) tick();
        first_addr = 16'h0070; last_addr = 16'h0070; start = 1'b1;
        tick(); start = 1'b0;
        wait_idle("R12");
        chk("R12", "pass", int'({pass, fail}), 2);
        chk("R12", "single pulse", n_pulse, 1);
        chk("R12", "pulsed original address", plog[0], 16'h0060);
        chk("R12", "other range untouched", dev[16'h70], 8'hFF);
    endtask

    initial begin
        dev_fill(8'hFF);
        mon_clr = 1'b1;
        repeat (3) tick();
        rst = 1'b0; mon_clr = 1'b0;
        tick();
        t_reset();
        t_per_byte();
        t_retry_edge();
        t_retry_fail();
        t_batch();
        t_raise();
        t_final_fade();
        t_busy_start();
        summary_and_end();
    end
endmodule